// File: doc/BRIEF.md
# Time-of-Day Counter with Event Time Tags

This block keeps time of day in the system clock domain. A sub-second tick counter advances on every clock and wraps once per second. A 32-bit seconds counter steps forward on each wrap. Software reaches the block through a 32-bit Wishbone slave port. Through that port it can overwrite either counter, with byte-lane masking, and it can read back the running time and the most recent time tag of each event.

Four event inputs request time tags. While an event input is high on a clock edge, the block freezes a three-value tag for that event: a per-event capture count, the seconds value and the tick value live in that cycle. On the bus each tag is four words wide. The fourth word reads as zero, so that all tags share one layout. The tick terminal count is a parameter. A real chip uses one second of 125 MHz ticks; simulation uses a short second.

Top module: `utc_timetag_core`

## Requirements
- R1: While reset is asserted, `sec_o`, `tick_o`, `sec_load_o`, `tick_load_o` and `bus_ack_o` are 0. Every tag word reads 0 after reset.
- R2: `tick_o` rises by one on each clock. When it is at or above `TICK_LAST`, it returns to 0 on the next clock. This also applies to a loaded value above the terminal count.
- R3: `sec_o` rises by one on exactly those clocks where `tick_o` wraps, and holds otherwise.
- R4: An accepted write to word 0 (seconds) or word 1 (ticks) sets that counter on the next clock. The new value is the old value with byte lane n (bits 8n+7:8n) replaced where `bus_sel_i[n]` is 1. Counting then continues from the loaded value. A seconds load overrides the wrap increment on the same clock.
- R5: `sec_load_o` and `tick_load_o` are high for exactly the one cycle in which the loaded value first appears.
- R6: A request is accepted in a cycle where `bus_cyc_i` and `bus_stb_i` are both high and `bus_ack_o` is low. `bus_ack_o` is high for one cycle, on the clock after acceptance. Without both cycle and strobe, there is no acknowledge and no load.
- R7: Read data reaches `bus_dat_o` with the acknowledge and reflects the cycle of acceptance. Word 0 is seconds and word 1 is ticks. Event e (e = 0 to 3) uses words 2+4e to 5+4e, in the order count word, seconds, ticks, zero word. Event bit 0 is trigger, 1 is acquisition start, 2 is acquisition stop and 3 is acquisition end.
- R8: Reads of words 0x12 to 0x1F return 0.
- R9: Writes to words 0x02 to 0x1F change no state.
- R10: In each cycle where `evt_i[e]` is high, tag e takes the `sec_o` and `tick_o` values of that cycle. At a wrap, the captured pair is therefore (old seconds, terminal tick).
- R11: The count word holds, in bits SEQ_W-1:0, the number of captures of that event since reset (modulo 2^SEQ_W). Its upper bits are 0, and the fourth tag word is always 0.
- R12: The four events capture independently. Simultaneous events each take their own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_adr_i | input | 5 | Word index |
| bus_dat_i | input | 32 | Write data |
| bus_sel_i | input | 4 | Byte-lane enables |
| bus_cyc_i | input | 1 | Bus cycle |
| bus_stb_i | input | 1 | Strobe |
| bus_we_i | input | 1 | Write enable |
| bus_dat_o | output | 32 | Read data |
| bus_ack_o | output | 1 | Acknowledge |
| evt_i | input | 4 | Event capture requests (trigger, start, stop, end) |
| sec_o | output | 32 | Live seconds count |
| tick_o | output | 32 | Live tick count |
| sec_load_o | output | 1 | Seconds load strobe |
| tick_load_o | output | 1 | Tick load strobe |

## Verification
The bench goes after the wrap edge in several ways.

- **Event on the terminal tick.** The bench fires an event exactly on the terminal tick. A design that sampled the next-state values would tag a seconds value one too high next to tick 0, or pair new seconds with an old tick.
- **Seconds write on the wrap clock.** A design that let the increment win over the load would read back one second too many.
- **Tick load above the terminal count.** A design that compared for equality would run on past the limit.
- **Partial byte-lane writes.** A design that ignored the byte enables would clobber the other bytes.
- **Writes to tag words.** A design with sloppy decode would corrupt a tag.
- **Strobe without cycle, or cycle without strobe.** A design with sloppy decode would acknowledge or load here.
- **Four simultaneous events.** Shared capture logic would drop or merge some of the tags.

// File: rtl/utc_tt_pkg.sv
package utc_tt_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned NUM_EVT  = 4;
  localparam int unsigned TAG_BASE = 2;
  localparam int unsigned TAG_SPAN = 4;
  localparam int unsigned LANES    = WORD_W / 8;

  typedef struct packed {
    logic [WORD_W-1:0] meta;
    logic [WORD_W-1:0] sec;
    logic [WORD_W-1:0] tick;
  } tag_t;
endpackage

// File: rtl/utc_tt_clock.sv
module utc_tt_clock
  import utc_tt_pkg::*;
#(
  parameter int unsigned TICK_LAST = 124_999_999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sec_i,
  input  logic              wr_tick_i,
  input  logic [WORD_W-1:0] wdat_i,
  input  logic [WORD_W-1:0] bmask_i,
  output logic [WORD_W-1:0] sec_o,
  output logic [WORD_W-1:0] tick_o,
  output logic              sec_ld_o,
  output logic              tick_ld_o
);
  localparam logic [WORD_W-1:0] LastW = WORD_W'(TICK_LAST);

  logic [WORD_W-1:0] sec_q, sec_d, tick_q, tick_d;
  logic              sec_ld_q, tick_ld_q, wrap;

  always_comb begin
    wrap   = (tick_q >= LastW);
    tick_d = wrap ? '0 : tick_q + WORD_W'(1);
    sec_d  = wrap ? sec_q + WORD_W'(1) : sec_q;
    if (wr_tick_i) tick_d = (tick_q & ~bmask_i) | (wdat_i & bmask_i);
    if (wr_sec_i)  sec_d  = (sec_q & ~bmask_i) | (wdat_i & bmask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q     <= '0;
      tick_q    <= '0;
      sec_ld_q  <= 1'b0;
      tick_ld_q <= 1'b0;
    end else begin
      sec_q     <= sec_d;
      tick_q    <= tick_d;
      sec_ld_q  <= wr_sec_i;
      tick_ld_q <= wr_tick_i;
    end
  end

  assign sec_o     = sec_q;
  assign tick_o    = tick_q;
  assign sec_ld_o  = sec_ld_q;
  assign tick_ld_o = tick_ld_q;
endmodule

// File: rtl/utc_tt_capture.sv
module utc_tt_capture
  import utc_tt_pkg::*;
#(
  parameter int unsigned SEQ_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [WORD_W-1:0] sec_i,
  input  logic [WORD_W-1:0] tick_i,
  output tag_t              tag_o
);
  tag_t             tag_q, tag_d;
  logic [SEQ_W-1:0] seq_nx;

  always_comb begin
    seq_nx     = tag_q.meta[SEQ_W-1:0] + SEQ_W'(1);
    tag_d.meta = WORD_W'(seq_nx);
    tag_d.sec  = sec_i;
    tag_d.tick = tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tag_q <= '0;
    else if (evt_i) tag_q <= tag_d;
  end

  assign tag_o = tag_q;
endmodule

// File: rtl/utc_tt_regbus.sv
module utc_tt_regbus
  import utc_tt_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        adr_i,
  input  logic [LANES-1:0]         sel_i,
  input  logic                     cyc_i,
  input  logic                     stb_i,
  input  logic                     we_i,
  input  logic [WORD_W-1:0]        sec_i,
  input  logic [WORD_W-1:0]        tick_i,
  input  tag_t [NUM_EVT-1:0]       tags_i,
  output logic [WORD_W-1:0]        rdat_o,
  output logic                     ack_o,
  output logic                     wr_sec_o,
  output logic                     wr_tick_o,
  output logic [WORD_W-1:0]        bmask_o
);
  logic              ack_q, req;
  logic [WORD_W-1:0] rdat_q, rd_mux;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign bmask_o[8*b +: 8] = {8{sel_i[b]}};
  end

  assign req       = cyc_i & stb_i & ~ack_q;
  assign wr_sec_o  = req & we_i & (adr_i == ADDR_W'(0));
  assign wr_tick_o = req & we_i & (adr_i == ADDR_W'(1));

  always_comb begin
    rd_mux = '0;
    if (adr_i == ADDR_W'(0)) rd_mux = sec_i;
    if (adr_i == ADDR_W'(1)) rd_mux = tick_i;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (adr_i == ADDR_W'(TAG_BASE + TAG_SPAN*e))     rd_mux = tags_i[e].meta;
      if (adr_i == ADDR_W'(TAG_BASE + TAG_SPAN*e + 1)) rd_mux = tags_i[e].sec;
      if (adr_i == ADDR_W'(TAG_BASE + TAG_SPAN*e + 2)) rd_mux = tags_i[e].tick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q <= req;
      if (req) rdat_q <= rd_mux;
    end
  end

  assign ack_o  = ack_q;
  assign rdat_o = rdat_q;
endmodule

// File: rtl/utc_timetag_core.sv
module utc_timetag_core
  import utc_tt_pkg::*;
#(
  parameter int unsigned TICK_LAST = 124_999_999,
  parameter int unsigned SEQ_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_adr_i,
  input  logic [WORD_W-1:0]  bus_dat_i,
  input  logic [LANES-1:0]   bus_sel_i,
  input  logic               bus_cyc_i,
  input  logic               bus_stb_i,
  input  logic               bus_we_i,
  output logic [WORD_W-1:0]  bus_dat_o,
  output logic               bus_ack_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [WORD_W-1:0]  sec_o,
  output logic [WORD_W-1:0]  tick_o,
  output logic               sec_load_o,
  output logic               tick_load_o
);
  logic               wr_sec, wr_tick;
  logic [WORD_W-1:0]  bmask;
  tag_t [NUM_EVT-1:0] tags;

  utc_tt_clock #(.TICK_LAST(TICK_LAST)) u_clock (
    .clk_i, .rst_ni,
    .wr_sec_i(wr_sec), .wr_tick_i(wr_tick),
    .wdat_i(bus_dat_i), .bmask_i(bmask),
    .sec_o, .tick_o,
    .sec_ld_o(sec_load_o), .tick_ld_o(tick_load_o)
  );

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    utc_tt_capture #(.SEQ_W(SEQ_W)) u_cap (
      .clk_i, .rst_ni,
      .evt_i(evt_i[e]), .sec_i(sec_o), .tick_i(tick_o),
      .tag_o(tags[e])
    );
  end

  utc_tt_regbus u_bus (
    .clk_i, .rst_ni,
    .adr_i(bus_adr_i), .sel_i(bus_sel_i),
    .cyc_i(bus_cyc_i), .stb_i(bus_stb_i), .we_i(bus_we_i),
    .sec_i(sec_o), .tick_i(tick_o), .tags_i(tags),
    .rdat_o(bus_dat_o), .ack_o(bus_ack_o),
    .wr_sec_o(wr_sec), .wr_tick_o(wr_tick), .bmask_o(bmask)
  );
endmodule

// File: rtl/utc_timetag_checker.sv
module utc_timetag_checker
  import utc_tt_pkg::*;
#(
  parameter int unsigned TICK_LAST = 124_999_999
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_adr_i,
  input logic              bus_cyc_i,
  input logic              bus_stb_i,
  input logic              bus_we_i,
  input logic              bus_ack_o,
  input logic [WORD_W-1:0] sec_o,
  input logic [WORD_W-1:0] tick_o,
  input logic              sec_load_o,
  input logic              tick_load_o
);
  localparam logic [WORD_W-1:0] LastW = WORD_W'(TICK_LAST);

  logic acc, ld_sec_req, ld_tick_req;
  assign acc         = bus_cyc_i & bus_stb_i & ~bus_ack_o;
  assign ld_sec_req  = acc & bus_we_i & (bus_adr_i == ADDR_W'(0));
  assign ld_tick_req = acc & bus_we_i & (bus_adr_i == ADDR_W'(1));

  p_tick_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_tick_req && tick_o < LastW) |=> tick_o == $past(tick_o) + WORD_W'(1));
  p_tick_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_tick_req && tick_o >= LastW) |=> tick_o == '0);
  p_sec_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_sec_req && tick_o < LastW) |=> $stable(sec_o));
  p_sec_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_sec_req && tick_o >= LastW) |=> sec_o == $past(sec_o) + WORD_W'(1));
  p_sec_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sec_req |=> sec_load_o);
  p_tick_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_tick_req |=> tick_load_o);
  p_strobe_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_load_o || tick_load_o) |=> !(sec_load_o || tick_load_o));
  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);
  p_ack_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cyc_i && bus_stb_i) |=> !bus_ack_o);
  p_ack_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> bus_ack_o);
endmodule

bind utc_timetag_core utc_timetag_checker #(.TICK_LAST(TICK_LAST)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_adr_i(bus_adr_i),
  .bus_cyc_i(bus_cyc_i), .bus_stb_i(bus_stb_i), .bus_we_i(bus_we_i),
  .bus_ack_o(bus_ack_o), .sec_o(sec_o), .tick_o(tick_o),
  .sec_load_o(sec_load_o), .tick_load_o(tick_load_o)
);

// File: tb/utc_timetag_core_tb_top.sv
`timescale 1ns/1ps
module utc_timetag_core_tb_top;
  localparam int unsigned LAST = 9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  adr = '0;
  logic [31:0] wdat = '0, rdat, sec, tick;
  logic [3:0]  sel = '0, evt = '0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0, ack, sld, tld;

  int checks = 0, errors = 0;
  bit done = 1'b0, live = 1'b0;

  // reference model, fed by the stimulus tasks
  logic        m_wr_sec = 1'b0, m_wr_tick = 1'b0;
  logic [31:0] m_dat = '0, m_msk = '0;
  logic [31:0] r_sec, r_tick;
  logic        r_sl, r_tl;
  logic [31:0] e_sec [4];
  logic [31:0] e_tick[4];
  int          e_cnt [4];

  // scoreboard
  logic [31:0] exp_q[$];
  bit          chk_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  utc_timetag_core #(.TICK_LAST(LAST), .SEQ_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_adr_i(adr), .bus_dat_i(wdat),
    .bus_sel_i(sel), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
    .bus_dat_o(rdat), .bus_ack_o(ack), .evt_i(evt), .sec_o(sec),
    .tick_o(tick), .sec_load_o(sld), .tick_load_o(tld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sec <= '0; r_tick <= '0; r_sl <= 1'b0; r_tl <= 1'b0;
    end else begin
      r_sl <= m_wr_sec;
      r_tl <= m_wr_tick;
      if (m_wr_tick)          r_tick <= (r_tick & ~m_msk) | (m_dat & m_msk);
      else if (r_tick >= LAST) r_tick <= '0;
      else                    r_tick <= r_tick + 1;
      if (m_wr_sec)           r_sec <= (r_sec & ~m_msk) | (m_dat & m_msk);
      else if (r_tick >= LAST) r_sec <= r_sec + 1;
    end
  end

  // monitor: live counters and bus read results
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(tick == r_tick, "R2 tick", tick, r_tick);
      check(sec == r_sec, "R3/R4 seconds", sec, r_sec);
      check(sld == r_sl, "R5 seconds strobe", {31'd0, sld}, {31'd0, r_sl});
      check(tld == r_tl, "R5 tick strobe", {31'd0, tld}, {31'd0, r_tl});
      if (ack && exp_q.size() > 0) begin
        automatic logic [31:0] ev = exp_q.pop_front();
        automatic bit          c  = chk_q.pop_front();
        automatic string       t  = tag_q.pop_front();
        if (c) check(rdat == ev, t, rdat, ev);
      end
    end
  end

  task automatic bus_op(input logic [4:0] a, input bit w, input logic [31:0] d,
                        input logic [3:0] s, input bit c, input logic [31:0] ev, input string t);
    adr = a; we = w; wdat = d; sel = s; cyc = 1'b1; stb = 1'b1;
    if (w) begin
      m_dat = d;
      for (int b = 0; b < 4; b++) m_msk[8*b +: 8] = {8{s[b]}};
      m_wr_sec  = (a == 5'd0);
      m_wr_tick = (a == 5'd1);
    end
    exp_q.push_back(ev); chk_q.push_back(c); tag_q.push_back(t);
    @(negedge clk);
    check(ack == 1'b1, "R6 ack after request", {31'd0, ack}, 32'd1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; m_wr_sec = 1'b0; m_wr_tick = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R6 ack single cycle", {31'd0, ack}, 32'd0);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] ev, input string t);
    bus_op(a, 1'b0, '0, 4'hF, 1'b1, ev, t);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_op(a, 1'b1, d, s, 1'b0, '0, "write");
  endtask

  task automatic fire(input logic [3:0] m);
    evt = m;
    for (int e = 0; e < 4; e++) if (m[e]) begin
      e_sec[e] = r_sec; e_tick[e] = r_tick; e_cnt[e]++;
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic wait_last();
    while (r_tick != LAST) @(negedge clk);
  endtask

  task automatic read_tags(input string t);
    for (int e = 0; e < 4; e++) begin
      rd(5'(2 + 4*e), 32'(e_cnt[e]), {t, " R11 count word"});
      rd(5'(3 + 4*e), e_sec[e],      {t, " R10 seconds"});
      rd(5'(4 + 4*e), e_tick[e],     {t, " R10 ticks"});
      rd(5'(5 + 4*e), 32'd0,         {t, " R11 zero word"});
    end
  endtask

  initial begin
    for (int e = 0; e < 4; e++) begin e_sec[e] = '0; e_tick[e] = '0; e_cnt[e] = 0; end
    repeat (3) @(negedge clk);
    check(sec == 0 && tick == 0, "R1 counters in reset", sec | tick, 32'd0);
    check(!ack && !sld && !tld, "R1 ack/strobes in reset", {29'd0, ack, sld, tld}, 32'd0);
    rst_n = 1'b1; live = 1'b1;
    read_tags("R1 after reset");
    repeat (25) @(negedge clk);
    rd(5'd0, r_sec, "R7 seconds word");
    rd(5'd1, r_tick, "R7 tick word");
    wr(5'd0, 32'h1234_5678, 4'hF);
    wr(5'd0, 32'h00AB_0000, 4'b0100);
    rd(5'd0, r_sec, "R4 lane-masked seconds");
    wr(5'd1, 32'h0000_0003, 4'b0001);
    wr(5'd1, 32'h0000_0100, 4'b0010);
    repeat (3) @(negedge clk);
    wait_last();
    wr(5'd0, 32'h0000_0040, 4'hF);
    rd(5'd0, r_sec, "R4 load beats wrap");
    fire(4'b0001);
    fire(4'b0010);
    wait_last();
    fire(4'b0100);
    repeat (4) @(negedge clk);
    fire(4'b1111);
    repeat (7) @(negedge clk);
    fire(4'b1000);
    read_tags("R12");
    wr(5'd3, 32'hFFFF_FFFF, 4'hF);
    wr(5'd14, 32'hFFFF_FFFF, 4'hF);
    wr(5'd20, 32'hFFFF_FFFF, 4'hF);
    rd(5'd3, e_sec[0], "R9 tag write ignored");
    rd(5'd14, 32'(e_cnt[3]), "R9 tag write ignored");
    rd(5'd18, 32'd0, "R8 unmapped 0x12");
    rd(5'd31, 32'd0, "R8 unmapped 0x1F");
    adr = 5'd0; wdat = 32'hDEAD_BEEF; sel = 4'hF; we = 1'b1; cyc = 1'b1; stb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ack == 1'b0, "R6 no ack without strobe", {31'd0, ack}, 32'd0);
    end
    cyc = 1'b0; stb = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ack == 1'b0, "R6 no ack without cycle", {31'd0, ack}, 32'd0);
    end
    stb = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule